// File: doc/BRIEF.md
# Banked Host Register Interface for a Disc Controller

This block is the byte-wide register window through which a host processor talks to a disc-drive controller. The host sees four byte addresses. Two bits held in the status byte select one of four banks, and the bank decides what the writes at addresses 1 to 3 and the read at address 3 mean. Behind the window sit three byte queues: a parameter queue that the host fills, and a response queue and a data queue that the drive side fills and the host drains. Two small registers, an interrupt enable and an interrupt flag, combine into one interrupt request line.

A command byte written by the host is handed to the command engine as a one-cycle strobe with the byte. After that the controller reports busy until the engine signals completion. The engine takes parameter bytes from the head of the parameter queue, pushes response and data bytes, and raises interrupt flag bits. The host acknowledges interrupts by writing ones to the flag register. Host reads return their byte in the cycle after the read strobe.

Top module: `disc_host_regs`

## Requirements
- R1: After reset the bank is 0, the controller is idle, all queues are empty, interrupt enable is 0x1F and interrupt flag is 0, so a status read returns 0x18 and an address-3 read in bank 0 returns 0xFF.
- R2: A host write to address 0 sets the bank to bits 1:0 of the value; no other status bit is changed by any host write.
- R3: A read of address 1 in any bank pops and returns the oldest response byte, or returns 0x00 and pops nothing when the queue is empty; a drive-side push into a full response queue is dropped.
- R4: A read of address 2 in any bank pops and returns the oldest data byte, or returns 0x00 when the data queue is empty.
- R5: A read of address 3 returns 0xE0 OR the enable register in banks 0 and 2, and the flag register (bits 7:5 zero) in banks 1 and 3.
- R6: A write to address 1 in bank 0 while idle produces a one-cycle command strobe carrying the written byte in the next cycle and makes the controller busy; while busy such writes are ignored; the done input returns it to idle.
- R7: A write to address 2 in bank 0 appends to the 16-entry parameter queue; when the queue is full the oldest entry is discarded so the new byte is kept. The drive side pops the head, shown on the head output (0x00 when empty).
- R8: A write to address 2 in bank 1 loads the enable register with bits 4:0 of the value.
- R9: A write to address 3 in bank 1 clears every flag bit whose matching bit in value bits 4:0 is one and leaves the others; a drive-side raise of a bit in the same cycle wins over the clear.
- R10: The interrupt output is high exactly when some bit is set in both the enable and the flag register.
- R11: Writes to address 1 in banks 1 to 3, to address 2 in banks 2 and 3, and to address 3 in banks 0, 2 and 3 change no state.
- R12: The status byte carries, from bit 2 upward: audio busy (always 0), parameter queue empty, parameter queue not full, response queue not empty, data queue not empty, controller busy; bits 1:0 are the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_ofs | input | 2 | Register address 0 to 3 |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after a read strobe, held until the next read |
| cmd_strobe | output | 1 | One-cycle pulse for an accepted command |
| cmd_byte | output | 8 | Last accepted command byte |
| cmd_done | input | 1 | Command engine finished; clears busy |
| resp_push | input | 1 | Drive side pushes a response byte |
| resp_byte | input | 8 | Response byte |
| data_push | input | 1 | Drive side pushes a data byte |
| data_byte | input | 8 | Data byte |
| param_pop | input | 1 | Drive side removes the head of the parameter queue |
| param_head | output | 8 | Oldest parameter byte, 0x00 when empty |
| irq_raise | input | 5 | Drive side sets these flag bits |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions assume that host accesses come as single-cycle strobes with a stable address and direction, and that the done input is only pulsed while a command is outstanding. They also assume the drive side pops the parameter queue only through its pop input and never holds a push across cycles without meaning to push twice. The stimulus issues one host access per cycle at most, pulses done only after a strobe was seen, and combines drive-side pushes with host reads on the same queue only where the ordering of pop before push is the behaviour being checked.

// File: rtl/disc_regs_pkg.sv
package disc_regs_pkg;

    localparam int BANK_W = 2;
    localparam int IRQ_W  = 5;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_STATUS,
        RD_RESP,
        RD_DATA,
        RD_IEN,
        RD_IFLAG
    } rd_sel_e;

    typedef struct packed {
        logic    status_wr;
        logic    cmd_wr;
        logic    param_wr;
        logic    ien_wr;
        logic    iflag_clr;
        logic    resp_rd;
        logic    data_rd;
        rd_sel_e rd_sel;
    } host_op_t;

endpackage

// File: rtl/hrx_fifo.sv
module hrx_fifo #(
    parameter int DEPTH       = 16,
    parameter int WIDTH       = 8,
    parameter bit DROP_OLDEST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic pop_ok, push_ok, adv_rd;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULL_CNT);
    assign pop_ok = pop && !empty;

    generate
        if (DROP_OLDEST) begin : g_drop
            assign push_ok = push;
            assign adv_rd  = pop_ok || (push && full);
        end else begin : g_keep
            assign push_ok = push && (!full || pop_ok);
            assign adv_rd  = pop_ok;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (adv_rd) begin
            st_d.rd = step(st_q.rd);
        end
        if (push_ok) begin
            st_d.wr = step(st_q.wr);
        end
        case ({push_ok, adv_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wr] <= push_data;
        end
    end

    assign head = empty ? '0 : mem[st_q.rd];

endmodule

// File: rtl/hrx_decode.sv
module hrx_decode
    import disc_regs_pkg::*;
(
    input  logic              en,
    input  logic              we,
    input  logic [1:0]        ofs,
    input  logic [BANK_W-1:0] bank,
    output host_op_t          op
);
    logic wr, rd, b0, b1;

    assign wr = en && we;
    assign rd = en && !we;
    assign b0 = (bank == 2'd0);
    assign b1 = (bank == 2'd1);

    always_comb begin
        op           = '0;
        op.rd_sel    = RD_NONE;
        op.status_wr = wr && (ofs == 2'd0);
        op.cmd_wr    = wr && (ofs == 2'd1) && b0;
        op.param_wr  = wr && (ofs == 2'd2) && b0;
        op.ien_wr    = wr && (ofs == 2'd2) && b1;
        op.iflag_clr = wr && (ofs == 2'd3) && b1;
        op.resp_rd   = rd && (ofs == 2'd1);
        op.data_rd   = rd && (ofs == 2'd2);
        if (rd) begin
            case (ofs)
                2'd0:    op.rd_sel = RD_STATUS;
                2'd1:    op.rd_sel = RD_RESP;
                2'd2:    op.rd_sel = RD_DATA;
                default: op.rd_sel = bank[0] ? RD_IFLAG : RD_IEN;
            endcase
        end
    end

endmodule

// File: rtl/disc_host_regs.sv
module disc_host_regs
    import disc_regs_pkg::*;
#(
    parameter int PARAM_DEPTH = 16,
    parameter int RESP_DEPTH  = 16,
    parameter int DATA_DEPTH  = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_en,
    input  logic             host_we,
    input  logic [1:0]       host_ofs,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             cmd_strobe,
    output logic [7:0]       cmd_byte,
    input  logic             cmd_done,
    input  logic             resp_push,
    input  logic [7:0]       resp_byte,
    input  logic             data_push,
    input  logic [7:0]       data_byte,
    input  logic             param_pop,
    output logic [7:0]       param_head,
    input  logic [IRQ_W-1:0] irq_raise,
    output logic             irq_out
);
    localparam logic [IRQ_W-1:0] IEN_RESET = '1;
    localparam logic [BYTE_W-IRQ_W-1:0] IEN_PAD = '1;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              busy;
        logic [IRQ_W-1:0]  ien;
        logic [IRQ_W-1:0]  iflag;
        logic [7:0]        rdata;
        logic              strobe;
        logic [7:0]        cmd;
    } regs_t;

    regs_t r_d, r_q;
    host_op_t op;

    logic [7:0] resp_head, data_head, status_byte;
    logic param_empty, param_full, resp_empty, resp_full, data_empty, data_full;

    logic [BANK_W-1:0] bank_q;
    logic              busy_q;
    logic [IRQ_W-1:0]  ien_q;
    logic [IRQ_W-1:0]  iflag_q;

    assign bank_q  = r_q.bank;
    assign busy_q  = r_q.busy;
    assign ien_q   = r_q.ien;
    assign iflag_q = r_q.iflag;

    hrx_decode u_dec (
        .en   (host_en),
        .we   (host_we),
        .ofs  (host_ofs),
        .bank (r_q.bank),
        .op   (op)
    );

    hrx_fifo #(.DEPTH(PARAM_DEPTH), .WIDTH(8), .DROP_OLDEST(1'b1)) u_param (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (op.param_wr),
        .push_data (host_wdata),
        .pop       (param_pop),
        .head      (param_head),
        .empty     (param_empty),
        .full      (param_full)
    );

    hrx_fifo #(.DEPTH(RESP_DEPTH), .WIDTH(8), .DROP_OLDEST(1'b0)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (resp_push),
        .push_data (resp_byte),
        .pop       (op.resp_rd),
        .head      (resp_head),
        .empty     (resp_empty),
        .full      (resp_full)
    );

    hrx_fifo #(.DEPTH(DATA_DEPTH), .WIDTH(8), .DROP_OLDEST(1'b0)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (data_push),
        .push_data (data_byte),
        .pop       (op.data_rd),
        .head      (data_head),
        .empty     (data_empty),
        .full      (data_full)
    );

    // Bit 2 (audio busy) has no source in this block and reads as 0.
    assign status_byte = {r_q.busy, !data_empty, !resp_empty, !param_full,
                          param_empty, 1'b0, r_q.bank};

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;

        case (op.rd_sel)
            RD_STATUS: r_d.rdata = status_byte;
            RD_RESP:   r_d.rdata = resp_head;
            RD_DATA:   r_d.rdata = data_head;
            RD_IEN:    r_d.rdata = {IEN_PAD, r_q.ien};
            RD_IFLAG:  r_d.rdata = {{(BYTE_W-IRQ_W){1'b0}}, r_q.iflag};
            default:   r_d.rdata = r_q.rdata;
        endcase

        if (op.status_wr) begin
            r_d.bank = host_wdata[BANK_W-1:0];
        end

        if (r_q.busy) begin
            if (cmd_done) begin
                r_d.busy = 1'b0;
            end
        end else if (op.cmd_wr) begin
            r_d.busy   = 1'b1;
            r_d.strobe = 1'b1;
            r_d.cmd    = host_wdata;
        end

        if (op.ien_wr) begin
            r_d.ien = host_wdata[IRQ_W-1:0];
        end

        r_d.iflag = r_q.iflag;
        if (op.iflag_clr) begin
            r_d.iflag = r_q.iflag & ~host_wdata[IRQ_W-1:0];
        end
        r_d.iflag = r_d.iflag | irq_raise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ien    <= IEN_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rdata = r_q.rdata;
    assign cmd_strobe = r_q.strobe;
    assign cmd_byte   = r_q.cmd;
    assign irq_out    = |(r_q.ien & r_q.iflag);

endmodule

// File: rtl/disc_host_regs_chk.sv
module disc_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_en,
    input logic       host_we,
    input logic [1:0] host_ofs,
    input logic [7:0] host_rdata,
    input logic [1:0] bank_q,
    input logic       busy_q,
    input logic       cmd_strobe,
    input logic       cmd_done,
    input logic [4:0] iflag_q,
    input logic [4:0] irq_raise,
    input logic       irq_out,
    input logic       param_full,
    input logic       param_pop,
    input logic       resp_empty
);
    // R2: bank only moves on a host write to address 0
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_en && host_we && host_ofs == 2'd0) |=> $stable(bank_q));

    // R6: no strobe can follow a cycle in which the controller was busy
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !cmd_strobe);

    // R6: a strobe leaves the controller busy
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> busy_q);

    // R3: reading an empty response queue yields zero
    p_resp_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !host_we && host_ofs == 2'd1 && resp_empty) |=> (host_rdata == 8'h00));

    // R7: a push into a full parameter queue keeps it full
    p_param_full_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && host_we && host_ofs == 2'd2 && bank_q == 2'd0 && param_full && !param_pop)
        |=> param_full);

    // R9: with nothing raised, flags never gain a bit
    p_flag_no_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raise == 5'd0) |=> ((iflag_q & ~$past(iflag_q)) == 5'd0));

    // R10: no flag set means no interrupt
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iflag_q == 5'd0) |-> !irq_out);

    // R6: done while idle has no effect on busy
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && cmd_done && !(host_en && host_we && host_ofs == 2'd1)) |=> !busy_q);

endmodule

bind disc_host_regs disc_host_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_en    (host_en),
    .host_we    (host_we),
    .host_ofs   (host_ofs),
    .host_rdata (host_rdata),
    .bank_q     (bank_q),
    .busy_q     (busy_q),
    .cmd_strobe (cmd_strobe),
    .cmd_done   (cmd_done),
    .iflag_q    (iflag_q),
    .irq_raise  (irq_raise),
    .irq_out    (irq_out),
    .param_full (param_full),
    .param_pop  (param_pop),
    .resp_empty (resp_empty)
);

// File: tb/disc_host_regs_bench.sv
`timescale 1ns/1ps
module disc_host_regs_bench;
    localparam int PD = 16;
    localparam int RD = 16;
    localparam int DD = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_en = 0, host_we = 0;
    logic [1:0] host_ofs = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       cmd_strobe;
    logic [7:0] cmd_byte;
    logic       cmd_done = 0;
    logic       resp_push = 0, data_push = 0, param_pop = 0;
    logic [7:0] resp_byte = 0, data_byte = 0;
    logic [7:0] param_head;
    logic [4:0] irq_raise = 0;
    logic       irq_out;

    always #5 clk = ~clk;

    disc_host_regs #(.PARAM_DEPTH(PD), .RESP_DEPTH(RD), .DATA_DEPTH(DD)) u_disc_host_regs (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte), .cmd_done(cmd_done),
        .resp_push(resp_push), .resp_byte(resp_byte), .data_push(data_push),
        .data_byte(data_byte), .param_pop(param_pop), .param_head(param_head),
        .irq_raise(irq_raise), .irq_out(irq_out)
    );

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit started = 0;

    // behavioural reference
    byte unsigned q_param[$], q_resp[$], q_data[$];
    logic [1:0] m_bank;
    logic       m_busy, m_strobe;
    logic [4:0] m_ien, m_iflag;
    logic [7:0] m_rdata, m_cmd, m_st;
    logic       nb;
    logic [4:0] clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_param.delete(); q_resp.delete(); q_data.delete();
            m_bank = 0; m_busy = 0; m_strobe = 0; m_ien = 5'h1F; m_iflag = 0;
            m_rdata = 0; m_cmd = 0;
        end else begin
            started = 1;
            m_st = {m_busy, q_data.size() != 0, q_resp.size() != 0,
                    q_param.size() < PD, q_param.size() == 0, 1'b0, m_bank};
            m_strobe = 0;
            clr = 0;
            if (host_en && !host_we) begin
                case (host_ofs)
                    2'd0: m_rdata = m_st;
                    2'd1: m_rdata = (q_resp.size() > 0) ? q_resp.pop_front() : 8'h00;
                    2'd2: m_rdata = (q_data.size() > 0) ? q_data.pop_front() : 8'h00;
                    default: m_rdata = m_bank[0] ? {3'b000, m_iflag} : {3'b111, m_ien};
                endcase
            end
            if (param_pop && q_param.size() > 0) void'(q_param.pop_front());
            nb = m_busy;
            if (m_busy && cmd_done) nb = 0;
            if (host_en && host_we) begin
                case (host_ofs)
                    2'd0: m_bank = host_wdata[1:0];
                    2'd1: if (m_bank == 0 && !m_busy) begin
                              m_strobe = 1; m_cmd = host_wdata; nb = 1;
                          end
                    2'd2: if (m_bank == 0) begin
                              if (q_param.size() == PD) void'(q_param.pop_front());
                              q_param.push_back(host_wdata);
                          end else if (m_bank == 1) m_ien = host_wdata[4:0];
                    default: if (m_bank == 1) clr = host_wdata[4:0];
                endcase
            end
            m_busy = nb;
            m_iflag = (m_iflag & ~clr) | irq_raise;
            if (resp_push && q_resp.size() < RD) q_resp.push_back(resp_byte);
            if (data_push && q_data.size() < DD) q_data.push_back(data_byte);
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "host_rdata", host_rdata, m_rdata);
            chk("R6", "cmd_strobe", {7'd0, cmd_strobe}, {7'd0, m_strobe});
            if (m_strobe) chk("R6", "cmd_byte", cmd_byte, m_cmd);
            chk("R10", "irq_out", {7'd0, irq_out}, {7'd0, |(m_ien & m_iflag)});
            chk("R7", "param_head", param_head, (q_param.size() > 0) ? q_param[0] : 8'h00);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        host_en = 0; host_we = 0; host_ofs = 0; host_wdata = 0;
        cmd_done = 0; resp_push = 0; data_push = 0; param_pop = 0; irq_raise = 0;
    endtask

    task automatic hw(input logic [1:0] ofs, input logic [7:0] v);
        host_en = 1; host_we = 1; host_ofs = ofs; host_wdata = v; tick();
    endtask

    task automatic hr(input logic [1:0] ofs);
        host_en = 1; host_we = 0; host_ofs = ofs; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1";
        hr(0); hr(3); tick();

        cur_req = "R2";
        hw(0, 8'hFF); hr(0); hr(3); hw(0, 8'h00); hr(0);

        cur_req = "R12";
        hw(2, 8'h11); hr(0);
        param_pop = 1; tick(); hr(0);

        cur_req = "R7";
        for (int i = 0; i < 18; i++) hw(2, 8'h40 + 8'(i));
        hr(0);
        param_pop = 1; hw(2, 8'h77);
        for (int i = 0; i < 17; i++) begin param_pop = 1; tick(); end
        hr(0);

        cur_req = "R6";
        hw(1, 8'h19); hr(0); hw(1, 8'h22); hr(0);
        cmd_done = 1; tick(); hr(0);
        hw(1, 8'h33); cmd_done = 1; hw(1, 8'h44); hr(0); hw(1, 8'h55);
        cmd_done = 1; tick();

        cur_req = "R3";
        resp_byte = 8'hA1; resp_push = 1; tick();
        resp_byte = 8'hA2; resp_push = 1; tick();
        hw(0, 8'h02); hr(0); hr(1); hr(1); hr(1);
        resp_byte = 8'hB0; resp_push = 1; hr(1); hr(1);
        for (int i = 0; i < 17; i++) begin resp_byte = 8'hC0 + 8'(i); resp_push = 1; tick(); end
        hr(0);
        for (int i = 0; i < 17; i++) hr(1);

        cur_req = "R4";
        hw(0, 8'h03);
        data_byte = 8'h5A; data_push = 1; tick();
        data_byte = 8'h6B; data_push = 1; tick();
        hr(0); hr(2); hr(2); hr(2);

        cur_req = "R8";
        hw(0, 8'h01); hw(2, 8'hFF); hw(0, 8'h00); hr(3);
        hw(0, 8'h01); hw(2, 8'h05); hw(0, 8'h02); hr(3);

        cur_req = "R9";
        irq_raise = 5'h1F; tick();
        hw(0, 8'h01); hr(3);
        hw(3, 8'hE4); hr(3);
        hw(3, 8'h01); hr(3);
        hw(3, 8'h00); hr(3);
        irq_raise = 5'h02; hw(3, 8'h02); hr(3);
        hw(3, 8'h1F); hr(3);

        cur_req = "R5";
        irq_raise = 5'h09; tick();
        for (int b = 0; b < 4; b++) begin hw(0, 8'(b)); hr(3); end

        cur_req = "R11";
        hw(0, 8'h01); hw(1, 8'h5C); hw(0, 8'h02); hw(1, 8'h5D); hw(2, 8'h00); hw(3, 8'h1F);
        hw(0, 8'h03); hw(1, 8'h5E); hw(2, 8'h00); hw(3, 8'h1F);
        hw(0, 8'h00); hw(3, 8'h1F);
        hr(0); hr(3); hw(0, 8'h01); hr(3);
        hw(0, 8'h00); hr(0);
        tick(); tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule